// File: doc/BRIEF.md
# Calendar-Day Real-Time Clock with Alarm

This block keeps wall-clock time as four separate counters (day, hour, minute and second) and advances them by one second whenever an externally supplied once-per-second strobe arrives while the block is switched on. Software controls it through a narrow 16-bit register port. The port has a byte-style address and a write strobe. Read data comes back one clock after the address is presented. Separate registers hold an alarm point as day, hour, minute and second, and the alarm is compared against the running time on every counted second.

Two interrupt sources feed a small status register: a per-second tick flag and an alarm flag. Writing a 1 to a status bit clears it. A companion enable register masks each source, and a single registered interrupt line is raised while any enabled source is pending. The control register carries a run bit and a two-bit field that records which reference clock frequency the external prescaler uses. Calendar conversion, leap years and any retry policy for reading a moving clock belong to software.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset every register reads 0x0000 and `irq` is 0.
- R2: `rdata` shows the register selected by `addr` one clock after `addr` is applied. The mapped byte offsets are: 0x00 hour/minute, 0x04 seconds, 0x08 alarm hour/minute, 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 interrupt enable, 0x20 day, 0x24 alarm day. Every other offset, including 0x1C, 0x28, 0x2C and 0x30, reads 0x0000.
- R3: The hour/minute and alarm hour/minute registers hold the hour in bits 12:8 and the minute in bits 5:0. Seconds registers use bits 5:0, and day registers use bits DAY_W-1:0. Other bits read 0. Writing one time register loads only that counter.
- R4: On a counted second, seconds go from 59 to 0 and carry into minutes, minutes go from 59 to 0 and carry into hours, and hours go from 23 to 0 and carry into the day counter.
- R5: The day counter is DAY_W bits wide and wraps from its all-ones value to 0 on a carry.
- R6: A strobe is counted only while control bit 7 is 1. While bit 7 is 0, strobes change neither the time nor the status.
- R7: The control register stores bit 7 (run) and bits 6:5 (reference clock select, 00 = 32768 Hz, 01 = 32000 Hz, 10 = 38400 Hz) as written. Its other bits read 0.
- R8: Status bit 4 sets on every counted second.
- R9: Status bit 2 sets on the counted second that makes day, hour, minute and second all equal to the alarm registers. It is evaluated once per counted second, so a match gives one event.
- R10: Writing 1 to status bit 2 or 4 clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same clock, the set wins.
- R11: The interrupt enable register holds bits 2 and 4 only. `irq` equals the OR over those bits of status AND enable, and is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-clock strobe once per second from the prescaler |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench loads 23:59:59 on the last day value and checks that one strobe clears every field at once. A design with a missing carry or a wrong wrap limit would leave a stale hour or day, or count to 60. It counts strobes while the run bit is low, because a design that ignores the run bit would move time or flag ticks. It lands on the alarm exactly, then moves past it after clearing the flag, so a level-style comparison that re-arms, or a comparison against the old time, shows up as a missing or repeated event. It also issues a status clear in the same clock as a strobe. A design that lets the clear win would lose an event, and a design that treats written zeros as clears would drop pending bits.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 6;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_HM    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SEC   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_AHM   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ASEC  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DAY   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ADAY  = 6'h24;

  localparam int HR_W  = 5;
  localparam int MIN_W = 6;
  localparam int SEC_W = 6;

  localparam int BIT_ALM  = 2;
  localparam int BIT_TICK = 4;
  localparam int BIT_RUN  = 7;
  localparam int BIT_CSEL = 5;
endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             ld_hm,
  input  logic             ld_sec,
  input  logic             ld_day,
  input  logic [HR_W-1:0]  ld_hr_val,
  input  logic [MIN_W-1:0] ld_mn_val,
  input  logic [SEC_W-1:0] ld_sc_val,
  input  logic [DAY_W-1:0] ld_day_val,
  output logic [HR_W-1:0]  hr_q,
  output logic [MIN_W-1:0] mn_q,
  output logic [SEC_W-1:0] sc_q,
  output logic [DAY_W-1:0] day_q,
  output logic [HR_W-1:0]  hr_d,
  output logic [MIN_W-1:0] mn_d,
  output logic [SEC_W-1:0] sc_d,
  output logic [DAY_W-1:0] day_d
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);

  logic sc_wrap, mn_wrap, hr_wrap;

  always_comb begin
    sc_wrap = (sc_q >= SEC_LAST);
    mn_wrap = (mn_q >= MIN_LAST);
    hr_wrap = (hr_q >= HR_LAST);
    sc_d  = sc_q;
    mn_d  = mn_q;
    hr_d  = hr_q;
    day_d = day_q;
    if (adv) begin
      sc_d = sc_wrap ? '0 : sc_q + 1'b1;
      if (sc_wrap) begin
        mn_d = mn_wrap ? '0 : mn_q + 1'b1;
        if (mn_wrap) begin
          hr_d = hr_wrap ? '0 : hr_q + 1'b1;
          if (hr_wrap) day_d = day_q + 1'b1;
        end
      end
    end
    if (ld_sec) sc_d = ld_sc_val;
    if (ld_hm) begin
      hr_d = ld_hr_val;
      mn_d = ld_mn_val;
    end
    if (ld_day) day_d = ld_day_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_q  <= '0;
      mn_q  <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else begin
      sc_q  <= sc_d;
      mn_q  <= mn_d;
      hr_q  <= hr_d;
      day_q <= day_d;
    end
  end

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && sc_q == SEC_LAST && !ld_sec) |=> (sc_q == '0));

  // R4
  hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && sc_q == SEC_LAST && mn_q == MIN_LAST && hr_q == HR_LAST && !ld_sec && !ld_hm)
    |=> (hr_q == '0 && mn_q == '0));

  // R5
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && sc_q == SEC_LAST && mn_q == MIN_LAST && hr_q == HR_LAST && day_q == '1
     && !ld_sec && !ld_hm && !ld_day) |=> (day_q == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld_sec && !ld_hm && !ld_day) |=> $stable({hr_q, mn_q, sc_q, day_q}));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_ahm,
  input  logic             ld_asec,
  input  logic             ld_aday,
  input  logic [HR_W-1:0]  ld_hr_val,
  input  logic [MIN_W-1:0] ld_mn_val,
  input  logic [SEC_W-1:0] ld_sc_val,
  input  logic [DAY_W-1:0] ld_day_val,
  input  logic             eval,
  input  logic [HR_W-1:0]  cur_hr,
  input  logic [MIN_W-1:0] cur_mn,
  input  logic [SEC_W-1:0] cur_sc,
  input  logic [DAY_W-1:0] cur_day,
  output logic [HR_W-1:0]  al_hr,
  output logic [MIN_W-1:0] al_mn,
  output logic [SEC_W-1:0] al_sc,
  output logic [DAY_W-1:0] al_day,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      al_hr  <= '0;
      al_mn  <= '0;
      al_sc  <= '0;
      al_day <= '0;
    end else begin
      if (ld_ahm) begin
        al_hr <= ld_hr_val;
        al_mn <= ld_mn_val;
      end
      if (ld_asec) al_sc  <= ld_sc_val;
      if (ld_aday) al_day <= ld_day_val;
    end
  end

  always_comb begin
    hit = eval && (cur_day == al_day) && (cur_hr == al_hr)
               && (cur_mn == al_mn) && (cur_sc == al_sc);
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_tick,
  input  logic       set_alm,
  input  logic       wr_stat,
  input  logic       wr_ien,
  input  logic [1:0] wr_bits,
  output logic [1:0] stat_q,
  output logic [1:0] ien_q,
  output logic       irq
);
  // bit 1 = tick source, bit 0 = alarm source
  logic [1:0] stat_d, ien_d, clr;

  always_comb begin
    clr    = wr_stat ? wr_bits : 2'b00;
    stat_d = (stat_q & ~clr) | {set_tick, set_alm};
    ien_d  = wr_ien ? wr_bits : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
      irq    <= |(stat_d & ien_d);
    end
  end

  // R9
  alm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[0]) |-> $past(set_alm));

  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wr_bits[0] && !set_alm) |=> !stat_q[0]);

  // R10
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q[1] && !(wr_stat && wr_bits[1])) |=> stat_q[1]);

  // R11
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & ien_q));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic             run_q;
  logic [1:0]       csel_q;
  logic             adv;
  logic             wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday, wr_ctrl, wr_stat, wr_ien;
  logic [HR_W-1:0]  hr_q, hr_d, a_hr;
  logic [MIN_W-1:0] mn_q, mn_d, a_mn;
  logic [SEC_W-1:0] sc_q, sc_d, a_sc;
  logic [DAY_W-1:0] day_q, day_d, a_day;
  logic             alm_hit;
  logic [1:0]       stat_q, ien_q;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    wr_hm   = wr_en && addr == OFS_HM;
    wr_sec  = wr_en && addr == OFS_SEC;
    wr_ahm  = wr_en && addr == OFS_AHM;
    wr_asec = wr_en && addr == OFS_ASEC;
    wr_ctrl = wr_en && addr == OFS_CTRL;
    wr_stat = wr_en && addr == OFS_STAT;
    wr_ien  = wr_en && addr == OFS_IEN;
    wr_day  = wr_en && addr == OFS_DAY;
    wr_aday = wr_en && addr == OFS_ADAY;
    adv     = tick_1hz && run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      csel_q <= 2'b00;
    end else if (wr_ctrl) begin
      run_q  <= wdata[BIT_RUN];
      csel_q <= wdata[BIT_CSEL +: 2];
    end
  end

  rtc_tod_counter #(.DAY_W(DAY_W)) u_tod (
    .clk(clk), .rst(rst), .adv(adv),
    .ld_hm(wr_hm), .ld_sec(wr_sec), .ld_day(wr_day),
    .ld_hr_val(wdata[8 +: HR_W]), .ld_mn_val(wdata[MIN_W-1:0]),
    .ld_sc_val(wdata[SEC_W-1:0]), .ld_day_val(wdata[DAY_W-1:0]),
    .hr_q(hr_q), .mn_q(mn_q), .sc_q(sc_q), .day_q(day_q),
    .hr_d(hr_d), .mn_d(mn_d), .sc_d(sc_d), .day_d(day_d)
  );

  rtc_alarm_match #(.DAY_W(DAY_W)) u_alm (
    .clk(clk), .rst(rst),
    .ld_ahm(wr_ahm), .ld_asec(wr_asec), .ld_aday(wr_aday),
    .ld_hr_val(wdata[8 +: HR_W]), .ld_mn_val(wdata[MIN_W-1:0]),
    .ld_sc_val(wdata[SEC_W-1:0]), .ld_day_val(wdata[DAY_W-1:0]),
    .eval(adv), .cur_hr(hr_d), .cur_mn(mn_d), .cur_sc(sc_d), .cur_day(day_d),
    .al_hr(a_hr), .al_mn(a_mn), .al_sc(a_sc), .al_day(a_day), .hit(alm_hit)
  );

  rtc_irq_ctrl u_irq (
    .clk(clk), .rst(rst),
    .set_tick(adv), .set_alm(alm_hit),
    .wr_stat(wr_stat), .wr_ien(wr_ien),
    .wr_bits({wdata[BIT_TICK], wdata[BIT_ALM]}),
    .stat_q(stat_q), .ien_q(ien_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_HM:   begin rd_mux[8 +: HR_W] = hr_q; rd_mux[MIN_W-1:0] = mn_q; end
      OFS_SEC:  rd_mux[SEC_W-1:0] = sc_q;
      OFS_AHM:  begin rd_mux[8 +: HR_W] = a_hr; rd_mux[MIN_W-1:0] = a_mn; end
      OFS_ASEC: rd_mux[SEC_W-1:0] = a_sc;
      OFS_CTRL: begin rd_mux[BIT_RUN] = run_q; rd_mux[BIT_CSEL +: 2] = csel_q; end
      OFS_STAT: begin rd_mux[BIT_TICK] = stat_q[1]; rd_mux[BIT_ALM] = stat_q[0]; end
      OFS_IEN:  begin rd_mux[BIT_TICK] = ien_q[1]; rd_mux[BIT_ALM] = ien_q[0]; end
      OFS_DAY:  rd_mux[DAY_W-1:0] = day_q;
      OFS_ADAY: rd_mux[DAY_W-1:0] = a_day;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R7
  run_bit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (run_q == $past(wdata[BIT_RUN])));

  // R6
  idle_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_en) |=> $stable(stat_q));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  localparam int DAY_W = 16;
  localparam int DMASK = (1 << DAY_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  int m_hr, m_mn, m_sc, m_day, a_hr, a_mn, a_sc, a_day, m_run, m_csel, m_stat, m_ien;

  rtc_calendar_core #(.DAY_W(DAY_W)) dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [15:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h00: return 16'((m_hr << 8) | m_mn);
      6'h04: return 16'(m_sc);
      6'h08: return 16'((a_hr << 8) | a_mn);
      6'h0C: return 16'(a_sc);
      6'h10: return 16'((m_run << 7) | (m_csel << 5));
      6'h14: return 16'(m_stat);
      6'h18: return 16'(m_ien);
      6'h20: return 16'(m_day);
      6'h24: return 16'(a_day);
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_stat & m_ien) != 0;
  endfunction

  task automatic model_reset();
    m_hr = 0; m_mn = 0; m_sc = 0; m_day = 0;
    a_hr = 0; a_mn = 0; a_sc = 0; a_day = 0;
    m_run = 0; m_csel = 0; m_stat = 0; m_ien = 0;
  endtask

  task automatic model_wr(input logic [5:0] a, input logic [15:0] d);
    case (a)
      6'h00: begin m_hr = int'(d[12:8]); m_mn = int'(d[5:0]); end
      6'h04: m_sc = int'(d[5:0]);
      6'h08: begin a_hr = int'(d[12:8]); a_mn = int'(d[5:0]); end
      6'h0C: a_sc = int'(d[5:0]);
      6'h10: begin m_run = int'(d[7]); m_csel = int'(d[6:5]); end
      6'h14: m_stat = m_stat & ~(int'(d) & 32'h14);
      6'h18: m_ien = int'(d) & 32'h14;
      6'h20: m_day = int'(d) & DMASK;
      6'h24: a_day = int'(d) & DMASK;
      default: ;
    endcase
  endtask

  task automatic model_tick();
    if (m_run == 1) begin
      if (m_sc >= 59) begin
        m_sc = 0;
        if (m_mn >= 59) begin
          m_mn = 0;
          if (m_hr >= 23) begin
            m_hr = 0;
            m_day = (m_day + 1) & DMASK;
          end else m_hr++;
        end else m_mn++;
      end else m_sc++;
      m_stat = m_stat | 32'h10;
      if (m_sc == a_sc && m_mn == a_mn && m_hr == a_hr && m_day == a_day)
        m_stat = m_stat | 32'h04;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    model_tick();
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic irq_chk(input string tag);
    chk(tag, {15'd0, irq}, {15'd0, exp_irq()});
  endtask

  task automatic rd_time(input string tag);
    rd_chk(tag, 6'h00);
    rd_chk(tag, 6'h04);
    rd_chk(tag, 6'h20);
  endtask

  logic [5:0] all_ofs [13] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18,
                               6'h1C, 6'h20, 6'h24, 6'h28, 6'h2C, 6'h30};

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register and the interrupt line
    for (int i = 0; i < 13; i++) rd_chk("R1", all_ofs[i]);
    irq_chk("R1");

    // R2: unmapped offsets read zero after writes to them
    do_wr(6'h1C, 16'hFFFF);
    do_wr(6'h2C, 16'hFFFF);
    rd_chk("R2", 6'h1C);
    rd_chk("R2", 6'h28);
    rd_chk("R2", 6'h30);
    rd_chk("R2", 6'h3C);

    // R3: field packing and independent loads
    do_wr(6'h00, 16'hFF3F & 16'h1A2B);
    do_wr(6'h04, 16'hFFEA);
    rd_chk("R3", 6'h00);
    rd_chk("R3", 6'h04);
    do_wr(6'h20, 16'h0123);
    rd_time("R3");

    // R6: strobes ignored while not running
    repeat (3) do_tick();
    rd_time("R6");
    rd_chk("R6", 6'h14);

    // R7: control readback
    do_wr(6'h10, 16'hFFFF);
    rd_chk("R7", 6'h10);
    do_wr(6'h10, 16'h00C0);
    rd_chk("R7", 6'h10);

    // R4: carries
    do_wr(6'h00, 16'h053B);
    do_wr(6'h04, 16'd59);
    do_tick();
    rd_time("R4");
    // R4 R5: full wrap on last day
    do_wr(6'h20, 16'(DMASK));
    do_wr(6'h00, 16'h173B);
    do_wr(6'h04, 16'd59);
    do_tick();
    rd_time("R5");

    // R8: tick flag
    rd_chk("R8", 6'h14);
    do_wr(6'h14, 16'h0010);
    rd_chk("R10", 6'h14);

    // R9 R11: alarm two seconds ahead, alarm source enabled
    do_wr(6'h24, 16'(m_day));
    do_wr(6'h08, 16'((m_hr << 8) | m_mn));
    do_wr(6'h0C, 16'(m_sc + 2));
    do_wr(6'h18, 16'h0004);
    do_tick();
    rd_chk("R9", 6'h14);
    irq_chk("R11");
    do_tick();
    rd_chk("R9", 6'h14);
    irq_chk("R11");
    // R10: writing zeros keeps flags
    do_wr(6'h14, 16'h0000);
    rd_chk("R10", 6'h14);
    do_wr(6'h14, 16'h0004);
    rd_chk("R10", 6'h14);
    irq_chk("R11");
    do_tick();
    rd_chk("R9", 6'h14);
    irq_chk("R11");

    // R10: set wins over a clear in the same clock
    do_wr(6'h18, 16'h0014);
    @(negedge clk);
    tick_1hz = 1'b1; wr_en = 1'b1; addr = 6'h14; wdata = 16'h0014;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 1'b0;
    model_wr(6'h14, 16'h0014);
    model_tick();
    rd_chk("R10", 6'h14);
    irq_chk("R11");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: do_tick();
        3: begin
          int s;
          s = ($urandom % 2) ? 59 : int'($urandom % 60);
          do_wr(6'h04, 16'(s));
          do_wr(6'h00, 16'((($urandom % 2) ? 23 : ($urandom % 24)) << 8 |
                           (($urandom % 2) ? 59 : ($urandom % 60))));
        end
        4: begin
          do_wr(6'h24, 16'(m_day));
          do_wr(6'h08, 16'((m_hr << 8) | m_mn));
          do_wr(6'h0C, 16'((m_sc + 1 + int'($urandom % 3)) % 60));
        end
        5: do_wr(6'h14, 16'($urandom));
        6: do_wr(6'h18, 16'($urandom));
        default: do_wr(6'h10, 16'(32'h80 | ($urandom & 32'h60) | (($urandom % 8 == 0) ? 0 : 32'h80)) & 16'hFFFF);
      endcase
      rd_chk("R2", all_ofs[$urandom % 13]);
      irq_chk("R11");
    end
    rd_time("R4");
    rd_chk("R8", 6'h14);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule